// File: doc/BRIEF.md
# Stored-program counter machine core

This block is a small processor in which the program, its operands and its data all sit in one file of 16-bit natural-number cells. Cell 1 is the program counter and cell 2 receives each fetched opcode. The core reads an opcode at the address in cell 1 and then reads one or two operand cells. After that it performs one of four actions: stop, add one to a cell, subtract one from a cell, or branch when a cell is zero.

While the core is stopped, a host loads a program and its data through a single-port access path. The host places the entry address in cell 1 and pulses `start`. It waits for `halted`, then reads results back through the same path. The `error` output marks a stop caused by a bad opcode or an address outside the file. A running cycle count lets a test confirm the fixed cost of each instruction. An unconditional branch is written as a zero-test of a cell that is kept at zero.

Top module: `tally_core`

## Requirements
- R1: After reset `halted` is 1, `error` is 0, `cycle_cnt` is 0 and every cell reads 0.
- R2: While halted, a host write (`host_we`=1) stores `host_wdata` into cell `host_addr`, and `host_rdata` always shows cell `host_addr`. Host writes made while running are ignored.
- R3: A `start` pulse while halted begins fetching at the address held in cell 1. A `start` pulse while running is ignored.
- R4: Opcodes are encoded 0=HALT, 1=INC, 2=DEC, 3=JZ. The fetched opcode is written into cell 2, and cell 1 advances past the opcode. HALT stops the core with cell 1 pointing just past the HALT cell.
- R5: INC h adds one to cell h. DEC h subtracts one from cell h, and a DEC of a cell holding 0 leaves it at 0 without error. Each takes one operand, and cell 1 advances past it.
- R6: JZ h,t tests cell h. If the cell is nonzero, execution continues at the cell after t. If it is zero, cell 1 is loaded with t.
- R7: Cycle costs are fixed: HALT 2, INC and DEC 3, JZ 4. `cycle_cnt` is cleared by an accepted start, rises by one in each running cycle, and holds while halted.
- R8: An opcode value above 3 stops the core with `error`=1 after 2 cycles. Cell 2 then holds the bad value.
- R9: A program counter value of 64 or more at any fetch stops the core with `error`=1 in that cycle. An operand address of 64 or more at execute does the same.
- R10: Program cells keep their values after execution. The 11-cell transfer loop at address 5 (a zero-test with jump to 15, a decrement of cell 18, an increment of cell 19, and a zero-test of always-zero cell 20 jumping to 5) moves n from cell 18 into cell 19 in 14n+6 cycles.
- R11: `error` stays set while halted and is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin execution at the address in cell 1 |
| host_we | input | 1 | Host write strobe, used only while halted |
| host_addr | input | 6 | Host cell address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of cell `host_addr` |
| halted | output | 1 | Core is stopped |
| error | output | 1 | Last stop was caused by a fault |
| cycle_cnt | output | 32 | Running cycles since the last start |

## Verification
A wrong sequencer state would change the cycle cost of an instruction. It therefore shows in `cycle_cnt` at the next stop, and in the cell 1 value read back after the stop. A wrong write-port decision would corrupt a data cell or a program cell. The host sees this only after `halted` rises, so every scenario reads back its program cells as well as its result cells. A fault path that fails to stop the core would appear as a cycle count larger than the one or two cycles the failing fetch should cost.

// File: rtl/tally_pkg.sv
// Shared types for the counter machine: sequencer states and opcode values.
package tally_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FOP,
        ST_FA,
        ST_FB,
        ST_EXEC
    } state_t;

    localparam int OP_HALT = 0;
    localparam int OP_INC  = 1;
    localparam int OP_DEC  = 2;
    localparam int OP_JZ   = 3;

    localparam int PC_CELL = 1;
    localparam int IR_CELL = 2;
endpackage

// File: rtl/tally_decode.sv
// Opcode classifier. Pure combinational logic: maps a cell value onto one of
// the four instruction classes or flags it as illegal.
// Assumes: the value is an unsigned cell content.
module tally_decode #(
    parameter int CELL_W = 16
) (
    input  logic [CELL_W-1:0] op,
    output logic              is_halt,
    output logic              is_inc,
    output logic              is_dec,
    output logic              is_jz,
    output logic              is_bad
);
    import tally_pkg::*;

    // Compare the value against each legal code.
    always_comb begin
        is_halt = (op == CELL_W'(OP_HALT));
        is_inc  = (op == CELL_W'(OP_INC));
        is_dec  = (op == CELL_W'(OP_DEC));
        is_jz   = (op == CELL_W'(OP_JZ));
        is_bad  = !(is_halt || is_inc || is_dec || is_jz);
    end
endmodule

// File: rtl/tally_regfile.sv
// Unified cell file holding program, operands and data.
// It has two write ports (port 0 wins on the same cell) and two asynchronous
// read ports, one for the host and one for the core. The program-counter and
// instruction cells are also exposed directly.
// Assumes: DEPTH > IR cell index; all cells clear on reset.
module tally_regfile #(
    parameter int CELL_W = 16,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w0_en,
    input  logic [ADDR_W-1:0] w0_addr,
    input  logic [CELL_W-1:0] w0_data,
    input  logic              w1_en,
    input  logic [ADDR_W-1:0] w1_addr,
    input  logic [CELL_W-1:0] w1_data,
    input  logic [ADDR_W-1:0] rh_addr,
    output logic [CELL_W-1:0] rh_data,
    input  logic [ADDR_W-1:0] rc_addr,
    output logic [CELL_W-1:0] rc_data,
    output logic [CELL_W-1:0] pc_q,
    output logic [CELL_W-1:0] ir_q
);
    import tally_pkg::*;

    logic [CELL_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        // Per-cell storage with port 0 taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[i] <= '0;
            else if (w0_en && (w0_addr == ADDR_W'(i)))
                cells[i] <= w0_data;
            else if (w1_en && (w1_addr == ADDR_W'(i)))
                cells[i] <= w1_data;
        end
    end

    // Read ports and fixed-role views.
    always_comb begin
        rh_data = cells[rh_addr];
        rc_data = cells[rc_addr];
        pc_q    = cells[PC_CELL];
        ir_q    = cells[IR_CELL];
    end
endmodule

// File: rtl/tally_seq.sv
// Fetch/execute sequencer. Each state lasts one cycle. The sequencer steers
// both write ports of the cell file, latches operands, range-checks
// addresses, keeps the error flag and counts running cycles. While idle it
// hands write port 0 to the host.
// Assumes: DEPTH is a power of two, so the range check is a test of the
// upper bits.
module tally_seq #(
    parameter int CELL_W = 16,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CELL_W-1:0] host_wdata,
    input  logic [CELL_W-1:0] pc_q,
    input  logic [CELL_W-1:0] ir_q,
    input  logic [CELL_W-1:0] rc_data,
    output logic [ADDR_W-1:0] rc_addr,
    output logic [CELL_W-1:0] dec_in,
    input  logic              is_halt,
    input  logic              is_inc,
    input  logic              is_dec,
    input  logic              is_jz,
    input  logic              is_bad,
    output logic              w0_en,
    output logic [ADDR_W-1:0] w0_addr,
    output logic [CELL_W-1:0] w0_data,
    output logic              w1_en,
    output logic [ADDR_W-1:0] w1_addr,
    output logic [CELL_W-1:0] w1_data,
    output logic              halted,
    output logic              error,
    output logic [CNT_W-1:0]  cycle_cnt
);
    import tally_pkg::*;

    state_t            state, nxt;
    logic [CELL_W-1:0] opnd_a, opnd_b;
    logic              err_q, err_set, pc_ok, a_ok, go;

    // Address checks, read steering and decoder input selection.
    always_comb begin
        pc_ok   = (pc_q[CELL_W-1:ADDR_W] == '0);
        a_ok    = (opnd_a[CELL_W-1:ADDR_W] == '0);
        rc_addr = (state == ST_EXEC) ? opnd_a[ADDR_W-1:0] : pc_q[ADDR_W-1:0];
        dec_in  = (state == ST_FOP) ? rc_data : ir_q;
        go      = (state == ST_IDLE) && start;
    end

    // Next state and write-port control for every phase.
    always_comb begin
        nxt     = state;
        err_set = 1'b0;
        w0_en   = 1'b0;
        w0_addr = ADDR_W'(PC_CELL);
        w0_data = pc_q + CELL_W'(1);
        w1_en   = 1'b0;
        w1_addr = ADDR_W'(IR_CELL);
        w1_data = rc_data;
        case (state)
            ST_IDLE: begin
                w0_en   = host_we;
                w0_addr = host_addr;
                w0_data = host_wdata;
                if (start) nxt = ST_FOP;
            end
            ST_FOP: begin
                if (!pc_ok) begin
                    err_set = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    w0_en = 1'b1;
                    w1_en = 1'b1;
                    nxt   = (is_halt || is_bad) ? ST_EXEC : ST_FA;
                end
            end
            ST_FA, ST_FB: begin
                if (!pc_ok) begin
                    err_set = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    w0_en = 1'b1;
                    nxt   = (state == ST_FA && is_jz) ? ST_FB : ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (is_halt) begin
                    nxt = ST_IDLE;
                end else if (is_bad || !a_ok) begin
                    err_set = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    nxt = ST_FOP;
                    if (is_inc || is_dec) begin
                        w0_en   = 1'b1;
                        w0_addr = opnd_a[ADDR_W-1:0];
                        w0_data = is_inc ? rc_data + CELL_W'(1)
                                : (rc_data == '0) ? '0 : rc_data - CELL_W'(1);
                    end else if (rc_data == '0) begin
                        w0_en   = 1'b1;
                        w0_data = opnd_b;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, operand latches, error flag and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            opnd_a    <= '0;
            opnd_b    <= '0;
            err_q     <= 1'b0;
            cycle_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_FA && pc_ok) opnd_a <= rc_data;
            if (state == ST_FB && pc_ok) opnd_b <= rc_data;
            if (go)
                err_q <= 1'b0;
            else if (err_set)
                err_q <= 1'b1;
            if (go)
                cycle_cnt <= '0;
            else if (state != ST_IDLE)
                cycle_cnt <= cycle_cnt + CNT_W'(1);
        end
    end

    // Status outputs.
    always_comb begin
        halted = (state == ST_IDLE);
        error  = err_q;
    end
endmodule

// File: rtl/tally_core.sv
// Top of the stored-program counter machine. It connects the cell file, the
// sequencer and the opcode classifier. The host owns the cell file whenever
// the core is halted.
// Assumes: DEPTH is a power of two and larger than 2.
module tally_core #(
    parameter int CELL_W = 16,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CELL_W-1:0] host_wdata,
    output logic [CELL_W-1:0] host_rdata,
    output logic              halted,
    output logic              error,
    output logic [CNT_W-1:0]  cycle_cnt
);
    logic              w0_en, w1_en;
    logic [ADDR_W-1:0] w0_addr, w1_addr, rc_addr;
    logic [CELL_W-1:0] w0_data, w1_data, rc_data, pc_q, ir_q, dec_in;
    logic              is_halt, is_inc, is_dec, is_jz, is_bad;

    tally_regfile #(.CELL_W(CELL_W), .DEPTH(DEPTH)) rf_i (
        .clk(clk), .rst_n(rst_n),
        .w0_en(w0_en), .w0_addr(w0_addr), .w0_data(w0_data),
        .w1_en(w1_en), .w1_addr(w1_addr), .w1_data(w1_data),
        .rh_addr(host_addr), .rh_data(host_rdata),
        .rc_addr(rc_addr), .rc_data(rc_data),
        .pc_q(pc_q), .ir_q(ir_q)
    );

    tally_decode #(.CELL_W(CELL_W)) dec_i (
        .op(dec_in), .is_halt(is_halt), .is_inc(is_inc),
        .is_dec(is_dec), .is_jz(is_jz), .is_bad(is_bad)
    );

    tally_seq #(.CELL_W(CELL_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .pc_q(pc_q), .ir_q(ir_q), .rc_data(rc_data),
        .rc_addr(rc_addr), .dec_in(dec_in),
        .is_halt(is_halt), .is_inc(is_inc), .is_dec(is_dec),
        .is_jz(is_jz), .is_bad(is_bad),
        .w0_en(w0_en), .w0_addr(w0_addr), .w0_data(w0_data),
        .w1_en(w1_en), .w1_addr(w1_addr), .w1_data(w1_data),
        .halted(halted), .error(error), .cycle_cnt(cycle_cnt)
    );
endmodule

// File: rtl/tally_core_chk.sv
// Property checker for tally_core, attached through bind. It watches only
// the status and counter ports.
module tally_core_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             halted,
    input logic             error,
    input logic [CNT_W-1:0] cycle_cnt
);
    // R7: the counter is frozen while halted and no start arrives.
    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> $stable(cycle_cnt));

    // R7: each running cycle adds exactly one.
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> (cycle_cnt == $past(cycle_cnt) + CNT_W'(1)));

    // R8: a fault flag never coexists with a running core.
    p_err_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> halted);

    // R11: an accepted start clears the flag and the counter.
    p_start_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && start) |=> (!error && !halted && cycle_cnt == '0));

    // R7: a clean stop costs at least the two HALT cycles.
    p_min_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(halted) && !error) |-> (cycle_cnt >= CNT_W'(2)));
endmodule

bind tally_core tally_core_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .halted(halted), .error(error), .cycle_cnt(cycle_cnt)
);

// File: tb/tally_core_tb_top.sv
// Directed bench for tally_core: one task per scenario, each checking its
// own results through the host port and the status outputs.
module tally_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        halted, error;
    logic [31:0] cycle_cnt;
    int          n_chk = 0;
    int          n_err = 0;
    int          ticks = 0;

    always #5 clk = ~clk;

    tally_core dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .halted(halted), .error(error),
        .cycle_cnt(cycle_cnt)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        ticks <= ticks + 1;
        if (ticks > 100000) begin
            n_err = n_err + 1;
            n_chk = n_chk + 1;
            $display("FAIL R7 watchdog: actual=%0d expected<=100000", ticks);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int a, input int v);
        @(negedge clk);
        host_we = 1'b1; host_addr = 6'(a); host_wdata = 16'(v);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic get(input int a, output int v);
        @(negedge clk);
        host_addr = 6'(a);
        #1 v = int'(host_rdata);
    endtask

    task automatic expect_cell(input int a, input int exp, input string req);
        int v;
        get(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic run_prog();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!halted) @(negedge clk);
    endtask

    task automatic t_reset();
        check(halted == 1'b1, "R1 halted", int'(halted), 1);
        check(error == 1'b0, "R1 error", int'(error), 0);
        check(cycle_cnt == 0, "R1 count", int'(cycle_cnt), 0);
        expect_cell(1, 0, "R1 cell1");
        expect_cell(45, 0, "R1 cell45");
    endtask

    task automatic t_host();
        put(33, 16'hBEEF);
        expect_cell(33, 16'hBEEF, "R2 host write/read");
    endtask

    task automatic t_halt();
        put(1, 5); put(5, 0);
        run_prog();
        check(cycle_cnt == 2, "R7 halt cost", int'(cycle_cnt), 2);
        check(error == 1'b0, "R4 halt no error", int'(error), 0);
        expect_cell(1, 6, "R3 R4 pc past halt");
        expect_cell(2, 0, "R4 ir holds opcode");
    endtask

    task automatic t_incdec();
        put(1, 5);
        put(5, 1); put(6, 30); put(7, 2); put(8, 31);
        put(9, 2); put(10, 32); put(11, 0);
        put(30, 7); put(31, 4); put(32, 0);
        run_prog();
        check(cycle_cnt == 11, "R7 inc/dec cost", int'(cycle_cnt), 11);
        check(error == 1'b0, "R5 no error on dec of zero", int'(error), 0);
        expect_cell(30, 8, "R5 inc");
        expect_cell(31, 3, "R5 dec");
        expect_cell(32, 0, "R5 dec of zero");
        expect_cell(1, 12, "R5 pc");
    endtask

    task automatic t_jz(input int tested, input int exp_pc);
        put(1, 40);
        put(40, 3); put(41, 50); put(42, 47); put(43, 0);
        put(47, 0); put(50, tested);
        run_prog();
        check(cycle_cnt == 6, "R6 R7 jz cost", int'(cycle_cnt), 6);
        expect_cell(1, exp_pc, "R6 jz target");
    endtask

    task automatic t_faults();
        put(1, 20); put(20, 9);
        run_prog();
        check(error == 1'b1, "R8 bad opcode", int'(error), 1);
        check(cycle_cnt == 2, "R8 bad opcode cost", int'(cycle_cnt), 2);
        expect_cell(2, 9, "R8 ir keeps bad value");
        put(1, 64);
        run_prog();
        check(error == 1'b1, "R9 pc range", int'(error), 1);
        check(cycle_cnt == 1, "R9 pc range cost", int'(cycle_cnt), 1);
        put(1, 20); put(20, 1); put(21, 70);
        run_prog();
        check(error == 1'b1, "R9 operand range", int'(error), 1);
        check(cycle_cnt == 3, "R9 operand range cost", int'(cycle_cnt), 3);
        put(1, 20); put(20, 0);
        run_prog();
        check(error == 1'b0, "R11 error cleared", int'(error), 0);
    endtask

    task automatic t_move(input int n);
        int prog [11] = '{3, 18, 15, 2, 18, 1, 19, 3, 20, 5, 0};
        put(1, 5);
        for (int i = 0; i < 11; i++) put(5 + i, prog[i]);
        put(18, n); put(19, 0); put(20, 0); put(25, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        host_we = 1'b1; host_addr = 6'd25; host_wdata = 16'h55; start = 1'b1;
        @(negedge clk);
        host_we = 1'b0; start = 1'b0;
        while (!halted) @(negedge clk);
        check(cycle_cnt == 14 * n + 6, "R10 R3 loop cost", int'(cycle_cnt), 14 * n + 6);
        check(error == 1'b0, "R10 no error", int'(error), 0);
        expect_cell(18, 0, "R10 source emptied");
        expect_cell(19, n, "R10 destination");
        expect_cell(1, 16, "R10 pc after halt");
        expect_cell(25, 0, "R2 write ignored while running");
        for (int i = 0; i < 11; i++) expect_cell(5 + i, prog[i], "R10 program intact");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host();
        t_halt();
        t_incdec();
        t_jz(1, 44);
        t_jz(0, 48);
        t_faults();
        t_move(5);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule